// File: doc/BRIEF.md
# Crosshair Cursor Generator

This block draws a two-color, full-screen crosshair over the video raster. It receives the coordinate of the pixel being scanned out from a shared raster counter, along with the cursor coordinate and a small set of control bits. From these it decides whether the current pixel lies on the vertical band, on the horizontal band, or on neither. The vertical band is centred on the cursor column and the horizontal band on the cursor row. Each band is 1, 3, 5 or 7 pixels thick and spans the whole active display. Coordinates count from (0,0) at the first displayed pixel, rightwards and downwards.

The block also merges its result with the sprite cursor pixel that is produced elsewhere. It emits one overlay request and one of two cursor colors. A priority bit chooses which color wins where an opaque sprite pixel and the crosshair fall on the same pixel. Bands are clipped at the screen edges and never wrap to the opposite side. All outputs are registered and appear one clock after the inputs that produced them.

Top module: `crosshair_gen`

## Requirements
- R1: While rst_n is low, xh_hit_o, xh_col_o, ovl_on_o and ovl_col_o are all 0.
- R2: During active display with the crosshair enabled, a pixel is on the vertical band when |pix_x_i - cur_x_i| <= N, where N is the value of ctrl_thick_i (0, 1, 2, 3 give widths 1, 3, 5, 7).
- R3: During active display with the crosshair enabled, a pixel is on the horizontal band when |pix_y_i - cur_y_i| <= N, with the same N as in R2. xh_hit_o is 1 when the pixel is on either band.
- R4: Distances are taken on unbounded integers. A cursor near one screen edge never lights pixels at the opposite end of the coordinate range (for example, cursor X 1 with pixel X 2046 at N = 3 is no hit).
- R5: With ctrl_en_i at 0, xh_hit_o is 0 for every pixel, and the overlay reflects only the sprite input.
- R6: On a crosshair pixel, xh_col_o equals ctrl_col_i. Off the crosshair, xh_col_o is 0.
- R7: Where xh_hit_o is 1 and spr_op_i is 1, ovl_on_o is 1. ovl_col_o equals spr_col_i when ctrl_prio_i is 0, and equals ctrl_col_i when ctrl_prio_i is 1.
- R8: Away from the crosshair, ovl_on_o follows spr_op_i and ovl_col_o equals spr_col_i when ovl_on_o is 1. Otherwise ovl_col_o is 0. On a crosshair pixel with a transparent sprite, ovl_col_o equals ctrl_col_i.
- R9: When pix_act_i is 0 (blanking), all four outputs are 0.
- R10: Every output reflects the inputs present at the previous rising clock edge (exactly one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_x_i | input | CW | Current pixel column |
| pix_y_i | input | CW | Current pixel row |
| pix_act_i | input | 1 | 1 during active display |
| cur_x_i | input | CW | Cursor column |
| cur_y_i | input | CW | Cursor row |
| ctrl_thick_i | input | 2 | Band half-width code N (width 2N+1) |
| ctrl_en_i | input | 1 | Crosshair enable |
| ctrl_col_i | input | 1 | Crosshair color select |
| ctrl_prio_i | input | 1 | Overlap color: 0 sprite, 1 crosshair |
| spr_op_i | input | 1 | Sprite pixel is opaque |
| spr_col_i | input | 1 | Sprite pixel color select |
| xh_hit_o | output | 1 | Pixel lies on the crosshair |
| xh_col_o | output | 1 | Crosshair color for this pixel |
| ovl_on_o | output | 1 | Cursor overlay replaces video |
| ovl_col_o | output | 1 | Resolved overlay color select |

## Verification
The crosshair band test and the sprite opacity input can both be true for the same pixel, so the band decision and the overlap resolution fall in the same cycle. The bench provokes this by placing the pixel on the cursor coordinate while driving an opaque sprite pixel whose color differs from the crosshair color. It runs that case once with each setting of the priority bit. The resolved overlay color is then judged against the sprite color in one case and the crosshair color in the other. Sprite-only, crosshair-only and blanking cases are also checked, to show that the overlap rule fires only when both sources are present.

// File: rtl/xh_pkg.sv
`timescale 1ns/1ps
package xh_pkg;

  // Control bundle as the generator sees it
  typedef struct packed {
    logic [1:0] half;   // half-width of each band, width = 2*half+1
    logic       en;     // crosshair enable
    logic       col;    // crosshair color select
    logic       prio;   // overlap color: 0 sprite, 1 crosshair
  } xh_ctrl_t;

  // Resolved overlay request
  typedef struct packed {
    logic on;
    logic col;
  } xh_ovl_t;

endpackage

// File: rtl/xh_band.sv
`timescale 1ns/1ps
// Tests one axis: is coord within +/- half of the cursor coordinate.
// Arithmetic is carried one bit wider than the coordinate so the
// comparison never wraps around the ends of the coordinate range.
module xh_band #(
  parameter int CW = 11,
  parameter int HW = 2
) (
  input  logic [CW-1:0] coord_i,
  input  logic [CW-1:0] cur_i,
  input  logic [HW-1:0] half_i,
  output logic          hit_o
);

  localparam int EW = CW + 1;

  logic [EW-1:0] coord_e;
  logic [EW-1:0] cur_e;
  logic [EW-1:0] half_e;
  logic [EW-1:0] coord_hi;
  logic [EW-1:0] cur_hi;
  logic          above_lo;
  logic          below_hi;

  always_comb begin
    coord_e  = {1'b0, coord_i};
    cur_e    = {1'b0, cur_i};
    half_e   = {{(EW-HW){1'b0}}, half_i};
    coord_hi = coord_e + half_e;
    cur_hi   = cur_e + half_e;
    above_lo = (coord_hi >= cur_e);
    below_hi = (coord_e <= cur_hi);
    hit_o    = above_lo & below_hi;
  end

endmodule

// File: rtl/xh_resolve.sv
`timescale 1ns/1ps
// Merges the crosshair result with the sprite pixel.
module xh_resolve
  import xh_pkg::*;
(
  input  logic    act_i,
  input  logic    xh_hit_i,
  input  logic    xh_col_i,
  input  logic    spr_op_i,
  input  logic    spr_col_i,
  input  logic    prio_i,
  output xh_ovl_t ovl_o
);

  always_comb begin
    ovl_o = '0;
    if (act_i) begin
      if (xh_hit_i && spr_op_i) begin
        ovl_o.on  = 1'b1;
        ovl_o.col = prio_i ? xh_col_i : spr_col_i;
      end else if (xh_hit_i) begin
        ovl_o.on  = 1'b1;
        ovl_o.col = xh_col_i;
      end else if (spr_op_i) begin
        ovl_o.on  = 1'b1;
        ovl_o.col = spr_col_i;
      end
    end
  end

endmodule

// File: rtl/crosshair_gen.sv
`timescale 1ns/1ps
module crosshair_gen
  import xh_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x_i,
  input  logic [CW-1:0] pix_y_i,
  input  logic          pix_act_i,
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [1:0]    ctrl_thick_i,
  input  logic          ctrl_en_i,
  input  logic          ctrl_col_i,
  input  logic          ctrl_prio_i,
  input  logic          spr_op_i,
  input  logic          spr_col_i,
  output logic          xh_hit_o,
  output logic          xh_col_o,
  output logic          ovl_on_o,
  output logic          ovl_col_o
);

  localparam int NAX = 2;   // axis 0 = X (vertical band), axis 1 = Y
  localparam int HW  = 2;

  xh_ctrl_t      ctrl;
  logic [CW-1:0] pos   [NAX];
  logic [CW-1:0] cur   [NAX];
  logic [NAX-1:0] band_hit;

  always_comb begin
    ctrl.half = ctrl_thick_i;
    ctrl.en   = ctrl_en_i;
    ctrl.col  = ctrl_col_i;
    ctrl.prio = ctrl_prio_i;
    pos[0] = pix_x_i;
    pos[1] = pix_y_i;
    cur[0] = cur_x_i;
    cur[1] = cur_y_i;
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    xh_band #(
      .CW (CW),
      .HW (HW)
    ) i_band (
      .coord_i (pos[a]),
      .cur_i   (cur[a]),
      .half_i  (ctrl.half),
      .hit_o   (band_hit[a])
    );
  end

  // next-state
  logic    hit_d;
  logic    col_d;
  xh_ovl_t ovl_d;

  always_comb begin
    hit_d = pix_act_i & ctrl.en & (|band_hit);
    col_d = hit_d & ctrl.col;
  end

  xh_resolve i_resolve (
    .act_i     (pix_act_i),
    .xh_hit_i  (hit_d),
    .xh_col_i  (col_d),
    .spr_op_i  (spr_op_i),
    .spr_col_i (spr_col_i),
    .prio_i    (ctrl.prio),
    .ovl_o     (ovl_d)
  );

  // registers
  logic    hit_q;
  logic    col_q;
  xh_ovl_t ovl_q;
  logic    armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      col_q   <= 1'b0;
      ovl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      col_q   <= col_d;
      ovl_q   <= ovl_d;
      armed_q <= 1'b1;
    end
  end

  assign xh_hit_o  = hit_q;
  assign xh_col_o  = col_q;
  assign ovl_on_o  = ovl_q.on;
  assign ovl_col_o = ovl_q.col;

  // R5
  dis_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(ctrl_en_i)) |-> !xh_hit_o);

  // R9
  blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(pix_act_i)) |-> (!xh_hit_o && !ovl_on_o && !ovl_col_o));

  // R6
  hit_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && xh_hit_o) |-> (xh_col_o == $past(ctrl_col_i)));

  // R7
  overlap_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && xh_hit_o && $past(spr_op_i)) |->
      (ovl_on_o && ovl_col_o == ($past(ctrl_prio_i) ? $past(ctrl_col_i) : $past(spr_col_i))));

  // R8
  ovl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !xh_hit_o && !$past(spr_op_i)) |-> (!ovl_on_o && !ovl_col_o));

endmodule

// File: tb/test_crosshair_gen.sv
`timescale 1ns/1ps
module test_crosshair_gen;

  localparam int CW = 11;

  typedef struct packed {
    logic [CW-1:0] px;
    logic [CW-1:0] py;
    logic          act;
    logic [CW-1:0] cx;
    logic [CW-1:0] cy;
    logic [1:0]    thick;
    logic          en;
    logic          col;
    logic          prio;
    logic          sop;
    logic          scol;
    logic          eh;
    logic          ec;
    logic          eo;
    logic          eoc;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    // R2 vertical band, width 1 centre and one off
    '{11'd100, 11'd50,  1'b1, 11'd100, 11'd300, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},
    '{11'd101, 11'd50,  1'b1, 11'd100, 11'd300, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    // R2 width 7 edge in and edge out
    '{11'd103, 11'd50,  1'b1, 11'd100, 11'd300, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},
    '{11'd104, 11'd50,  1'b1, 11'd100, 11'd300, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    // R2 width 3 left edge
    '{11'd99,  11'd50,  1'b1, 11'd100, 11'd300, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},
    // R3 horizontal band, width 5 edge in and edge out, color 1
    '{11'd500, 11'd298, 1'b1, 11'd100, 11'd300, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3},
    '{11'd500, 11'd297, 1'b1, 11'd100, 11'd300, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    // R4 no wrap: cursor at X 1, pixel at top of range
    '{11'd2046, 11'd50, 1'b1, 11'd1,   11'd300, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    // R4 clipped band still drawn at X 0
    '{11'd0,   11'd50,  1'b1, 11'd1,   11'd300, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    // R4 no wrap on Y: cursor row 0, pixel row 2047
    '{11'd1,   11'd2047, 1'b1, 11'd500, 11'd0,  2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    // R5 disabled crosshair, sprite only
    '{11'd100, 11'd300, 1'b1, 11'd100, 11'd300, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},
    // R7 overlap, prio 0 -> sprite color
    '{11'd100, 11'd50,  1'b1, 11'd100, 11'd300, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7},
    // R7 overlap, prio 1 -> crosshair color
    '{11'd100, 11'd50,  1'b1, 11'd100, 11'd300, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7},
    // R8 sprite away from crosshair
    '{11'd400, 11'd50,  1'b1, 11'd100, 11'd300, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
    // R9 blanking silences everything
    '{11'd100, 11'd300, 1'b0, 11'd100, 11'd300, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},
    // R6 color 0 with prio set, transparent sprite
    '{11'd100, 11'd300, 1'b1, 11'd100, 11'd300, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6}
  };

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] pix_x, pix_y, cur_x, cur_y;
  logic          pix_act;
  logic [1:0]    thick;
  logic          en, col, prio, sop, scol;
  logic          hit, hcol, oon, ocol;

  int checks = 0;
  int errors = 0;

  crosshair_gen #(.CW(CW)) i_crosshair_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_x_i      (pix_x),
    .pix_y_i      (pix_y),
    .pix_act_i    (pix_act),
    .cur_x_i      (cur_x),
    .cur_y_i      (cur_y),
    .ctrl_thick_i (thick),
    .ctrl_en_i    (en),
    .ctrl_col_i   (col),
    .ctrl_prio_i  (prio),
    .spr_op_i     (sop),
    .spr_col_i    (scol),
    .xh_hit_o     (hit),
    .xh_col_o     (hcol),
    .ovl_on_o     (oon),
    .ovl_col_o    (ocol)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check4(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {hit, hcol, oon, ocol};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s hit/col/ovl/ovlcol actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    pix_x = v.px; pix_y = v.py; pix_act = v.act;
    cur_x = v.cx; cur_y = v.cy; thick = v.thick;
    en = v.en; col = v.col; prio = v.prio;
    sop = v.sop; scol = v.scol;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    apply(TBL[0]);
    repeat (3) @(negedge clk);
    // R1: outputs held low in reset despite a hitting input
    check4("R1", 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      check4($sformatf("R%0d row %0d", TBL[i].rq, i),
             {TBL[i].eh, TBL[i].ec, TBL[i].eo, TBL[i].eoc});
    end

    // R10: one cycle latency, no-hit then hit
    apply(TBL[1]);
    @(negedge clk);
    apply(TBL[5]);
    #1;
    check4("R10 before edge", 4'b0000);
    @(negedge clk);
    check4("R10 after edge", 4'b1111);

    // R5: enable dropped mid-run with crosshair pixel, no sprite
    apply(TBL[0]);
    en = 1'b0;
    @(negedge clk);
    check4("R5 disabled no sprite", 4'b0000);

    // R1: asynchronous reset mid-frame clears outputs at once
    apply(TBL[5]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check4("R1 async", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check4("R1 recover", 4'b1111);

    finish_run();
  end

endmodule